// File: doc/BRIEF.md
# Program Status Register Unit

This unit keeps the live processor status word and one saved status word for each exception bank that owns one. It handles the two move-to-status operations. One writes the live word and the other writes the saved word of the current bank. Each takes a four-bit byte-field mask, so any chosen set of byte fields can be replaced in one cycle. It also folds an ALU outcome into the four condition flags. It takes the result word, the sign bits of both operands, and a code that says whether the operation was a logical one, an add or a subtract.

The live mode sits in the low five bits of the status word. When a write to the live word changes that field, the unit raises a one-cycle bank-switch pulse and reports the old and new mode, so the register file can swap its banked registers. In the two user modes the live word is privilege-gated: only the flag byte can be written there. Saved words are reached only through banks that have one. A read through a bank without one returns the live word, and a write to it is dropped.

All state changes land on the rising clock edge and are visible on the outputs from the following cycle. The saved-word read port is combinational over the registered state.

Top module: `psr_unit`

## Requirements
- R1: After reset the live word is 0x000000D3 (supervisor mode 0x13 in bits 4:0, both interrupt masks set), every saved word is zero and `bank_sw` is low.
- R2: In any mode other than 0x00 and 0x10, a live write replaces byte i of the live word with byte i of `wr_data` for each set bit i of `field_mask` and keeps the other bytes (bit 0: bits 7:0, bit 1: bits 15:8, bit 2: bits 23:16, bit 3: bits 31:24). With no write and no flag update the live word holds.
- R3: In user modes 0x00 and 0x10 a live write changes only bits 31:24 (if mask bit 3 is set). Mask bits 0 to 2 are ignored.
- R4: A saved write goes to the bank of the current mode and honours all four mask bits in any mode. The banks are: fast-interrupt for 0x01/0x11, interrupt for 0x02/0x12, supervisor for 0x03/0x13, abort for 0x17 and undefined for 0x1B. In every other mode the saved write is dropped.
- R5: `rd_saved` shows the saved word of the bank selected by `rd_mode`, or the live word when that mode has no saved word.
- R6: On a flag update the N flag (bit 31) takes result bit 31 and Z (bit 30) is set only for an all-zero result. A logical update keeps C (bit 29) and V (bit 28).
- R7: On an add, C = (a&b)|(a&~r)|(b&~r) over the sign bits, and V is set when both operand signs agree and the result sign differs.
- R8: On a subtract, C is not-borrow: (a&~b)|(a&~r)|(~b&~r). V is set when the operand signs differ and the result sign differs from the first operand.
- R9: A live write that changes bits 4:0 raises `bank_sw` for exactly one cycle, with `sw_from_mode` and `sw_to_mode` giving the old and new mode. Otherwise `bank_sw` stays low.
- R10: When a live write and a flag update occur in the same cycle, the write is applied and the flag update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cur_en | input | 1 | Write the live status word |
| wr_saved_en | input | 1 | Write the saved word of the current bank |
| field_mask | input | 4 | Byte-field enables for either write |
| wr_data | input | 32 | Write data |
| flag_kind | input | 2 | 0 none, 1 logical, 2 add, 3 subtract |
| opnd_a_sign | input | 1 | Sign bit of first ALU operand |
| opnd_b_sign | input | 1 | Sign bit of second ALU operand |
| alu_res | input | 32 | ALU result |
| rd_mode | input | 5 | Mode whose saved word is read |
| cur_psr | output | 32 | Live status word |
| rd_saved | output | 32 | Saved word for `rd_mode`, or live word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| bank_sw | output | 1 | One-cycle bank-switch pulse |
| sw_from_mode | output | 5 | Mode before the switch |
| sw_to_mode | output | 5 | Mode after the switch |

## Verification
The bench drives signed-boundary operands. These include the largest positive plus one, all-ones plus one, equal subtraction, zero minus one and the most negative minus one. A unit with the subtract carry inverted to a borrow, or with overflow taken from the wrong operand, gives the wrong C or V on exactly these cases. It writes all-ones with a full mask from user mode, where a missing privilege gate would corrupt the mode and control bytes. It also attempts saved writes from a mode with no bank and from user mode; if these were not dropped, another bank's word would change. It walks through modes with and without saved words and collides a live write with a flag update. A unit that mis-maps banks returns the wrong word, and one that lets the update win returns the wrong flag byte.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int unsigned PSR_W    = 32;
  localparam int unsigned MODE_W   = 5;
  localparam int unsigned N_FIELDS = 4;
  localparam int unsigned N_SAVED  = 5;
  localparam int unsigned SLOT_W   = $clog2(N_SAVED);
  localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_LOGIC = 2'd1,
    FK_ADD   = 2'd2,
    FK_SUB   = 2'd3
  } flag_kind_e;

  typedef enum logic [2:0] {
    BK_USER, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_VOID
  } bank_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic bank_has_saved(input bank_e b);
    return b inside {BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND};
  endfunction

  function automatic logic [SLOT_W-1:0] bank_slot(input bank_e b);
    case (b)
      BK_FIQ:  return SLOT_W'(0);
      BK_IRQ:  return SLOT_W'(1);
      BK_SVC:  return SLOT_W'(2);
      BK_ABT:  return SLOT_W'(3);
      BK_UND:  return SLOT_W'(4);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/psr_bank_map.sv
module psr_bank_map
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank
);
  always_comb begin
    case (mode)
      5'h00, 5'h10: bank = BK_USER;
      5'h01, 5'h11: bank = BK_FIQ;
      5'h02, 5'h12: bank = BK_IRQ;
      5'h03, 5'h13: bank = BK_SVC;
      5'h17:        bank = BK_ABT;
      5'h1B:        bank = BK_UND;
      5'h1F:        bank = BK_SYS;
      default:      bank = BK_VOID;
    endcase
  end
endmodule

// File: rtl/psr_field_merge.sv
module psr_field_merge #(
  parameter int unsigned W  = 32,
  parameter int unsigned NF = 4
) (
  input  logic [W-1:0]  old_word,
  input  logic [W-1:0]  new_word,
  input  logic [NF-1:0] mask,
  output logic [W-1:0]  merged
);
  localparam int unsigned FW = W / NF;

  for (genvar f = 0; f < NF; f++) begin : g_field
    assign merged[f*FW +: FW] = mask[f] ? new_word[f*FW +: FW] : old_word[f*FW +: FW];
  end
endmodule

// File: rtl/psr_flag_calc.sv
module psr_flag_calc
  import psr_pkg::*;
#(
  parameter int unsigned W = PSR_W
) (
  input  flag_kind_e kind,
  input  logic       a_sign,
  input  logic       b_sign,
  input  logic [W-1:0] res,
  input  nzcv_t      old_f,
  output nzcv_t      new_f
);
  logic r_sign;
  assign r_sign = res[W-1];

  always_comb begin
    new_f   = old_f;
    new_f.n = r_sign;
    new_f.z = (res == '0);
    case (kind)
      FK_ADD: begin
        new_f.c = (a_sign & b_sign) | (a_sign & ~r_sign) | (b_sign & ~r_sign);
        new_f.v = (a_sign == b_sign) && (r_sign != a_sign);
      end
      FK_SUB: begin
        new_f.c = (a_sign & ~b_sign) | (a_sign & ~r_sign) | (~b_sign & ~r_sign);
        new_f.v = (a_sign != b_sign) && (r_sign != a_sign);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_cur_en,
  input  logic                wr_saved_en,
  input  logic [N_FIELDS-1:0] field_mask,
  input  logic [PSR_W-1:0]    wr_data,
  input  logic [1:0]          flag_kind,
  input  logic                opnd_a_sign,
  input  logic                opnd_b_sign,
  input  logic [PSR_W-1:0]    alu_res,
  input  logic [MODE_W-1:0]   rd_mode,
  output logic [PSR_W-1:0]    cur_psr,
  output logic [PSR_W-1:0]    rd_saved,
  output logic                flag_n,
  output logic                flag_z,
  output logic                flag_c,
  output logic                flag_v,
  output logic                bank_sw,
  output logic [MODE_W-1:0]   sw_from_mode,
  output logic [MODE_W-1:0]   sw_to_mode
);
  localparam logic [N_FIELDS-1:0] FLAG_ONLY = {1'b1, {(N_FIELDS-1){1'b0}}};

  logic [PSR_W-1:0]  cur_q, cur_d;
  logic [PSR_W-1:0]  saved_q [N_SAVED];
  logic              sw_q;
  logic [MODE_W-1:0] from_q, to_q;

  bank_e cur_bank, rd_bank;
  logic  cur_has, rd_has, cur_user, mode_chg;
  logic [SLOT_W-1:0] cur_slot, rd_slot;
  logic [N_FIELDS-1:0] cur_mask;
  logic [PSR_W-1:0] cur_merged, saved_merged;
  nzcv_t old_f, new_f;
  flag_kind_e kind;

  psr_bank_map u_cur_map (.mode(cur_q[MODE_W-1:0]), .bank(cur_bank));
  psr_bank_map u_rd_map  (.mode(rd_mode),           .bank(rd_bank));

  assign cur_has  = bank_has_saved(cur_bank);
  assign rd_has   = bank_has_saved(rd_bank);
  assign cur_slot = bank_slot(cur_bank);
  assign rd_slot  = bank_slot(rd_bank);
  assign cur_user = (cur_bank == BK_USER);
  assign cur_mask = cur_user ? (field_mask & FLAG_ONLY) : field_mask;

  psr_field_merge #(.W(PSR_W), .NF(N_FIELDS)) u_cur_merge (
    .old_word(cur_q), .new_word(wr_data), .mask(cur_mask), .merged(cur_merged)
  );

  psr_field_merge #(.W(PSR_W), .NF(N_FIELDS)) u_saved_merge (
    .old_word(saved_q[cur_slot]), .new_word(wr_data), .mask(field_mask), .merged(saved_merged)
  );

  assign kind  = flag_kind_e'(flag_kind);
  assign old_f = nzcv_t'(cur_q[PSR_W-1 -: 4]);

  psr_flag_calc #(.W(PSR_W)) u_flags (
    .kind(kind), .a_sign(opnd_a_sign), .b_sign(opnd_b_sign),
    .res(alu_res), .old_f(old_f), .new_f(new_f)
  );

  always_comb begin
    if (wr_cur_en)
      cur_d = cur_merged;
    else if (kind != FK_NONE)
      cur_d = {new_f, cur_q[PSR_W-5:0]};
    else
      cur_d = cur_q;
  end

  assign mode_chg = wr_cur_en && (cur_merged[MODE_W-1:0] != cur_q[MODE_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= PSR_RESET;
      sw_q   <= 1'b0;
      from_q <= '0;
      to_q   <= '0;
    end else begin
      cur_q <= cur_d;
      sw_q  <= mode_chg;
      if (mode_chg) begin
        from_q <= cur_q[MODE_W-1:0];
        to_q   <= cur_merged[MODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < N_SAVED; s++) begin
      if (!rst_n)
        saved_q[s] <= '0;
      else if (wr_saved_en && cur_has && (cur_slot == SLOT_W'(s)))
        saved_q[s] <= saved_merged;
    end
  end

  assign cur_psr      = cur_q;
  assign rd_saved     = rd_has ? saved_q[rd_slot] : cur_q;
  assign flag_n       = cur_q[PSR_W-1];
  assign flag_z       = cur_q[PSR_W-2];
  assign flag_c       = cur_q[PSR_W-3];
  assign flag_v       = cur_q[PSR_W-4];
  assign bank_sw      = sw_q;
  assign sw_from_mode = from_q;
  assign sw_to_mode   = to_q;
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_cur_en,
  input logic [3:0]  field_mask,
  input logic [31:0] wr_data,
  input logic [1:0]  flag_kind,
  input logic [31:0] alu_res,
  input logic [4:0]  rd_mode,
  input logic [31:0] cur_psr,
  input logic [31:0] rd_saved,
  input logic        flag_n,
  input logic        flag_z,
  input logic        bank_sw,
  input logic [4:0]  sw_from_mode,
  input logic [4:0]  sw_to_mode
);
  logic in_user;
  assign in_user = (cur_psr[4:0] == 5'h00) || (cur_psr[4:0] == 5'h10);

  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur_en && !in_user && field_mask == 4'hF) |=> (cur_psr == $past(wr_data))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cur_en && flag_kind == 2'd0) |=> $stable(cur_psr)); // R2

  AST_USER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur_en && in_user) |=> (cur_psr[23:0] == $past(cur_psr[23:0]))); // R3

  AST_NO_BANK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 5'h10 || rd_mode == 5'h1F || rd_mode == 5'h04) |-> (rd_saved == cur_psr)); // R5

  AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cur_en && flag_kind != 2'd0) |=> (flag_z == ($past(alu_res) == 32'd0) && flag_n == $past(alu_res[31]))); // R6

  AST_SWITCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur_en && !in_user && field_mask[0] && wr_data[4:0] != cur_psr[4:0])
    |=> (bank_sw && sw_to_mode == $past(wr_data[4:0]) && sw_from_mode == $past(cur_psr[4:0]))); // R9

  AST_SWITCH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cur_en |=> !bank_sw); // R9

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur_en && field_mask[3] && flag_kind != 2'd0) |=> (cur_psr[31:24] == $past(wr_data[31:24]))); // R10
endmodule

bind psr_unit psr_unit_chk u_psr_chk (
  .clk(clk), .rst_n(rst_n), .wr_cur_en(wr_cur_en), .field_mask(field_mask),
  .wr_data(wr_data), .flag_kind(flag_kind), .alu_res(alu_res), .rd_mode(rd_mode),
  .cur_psr(cur_psr), .rd_saved(rd_saved), .flag_n(flag_n), .flag_z(flag_z),
  .bank_sw(bank_sw), .sw_from_mode(sw_from_mode), .sw_to_mode(sw_to_mode)
);

// File: tb/psr_unit_bench.sv
module psr_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_cur_en = 1'b0, wr_saved_en = 1'b0;
  logic [3:0]  field_mask = '0;
  logic [31:0] wr_data = '0, alu_res = '0;
  logic [1:0]  flag_kind = '0;
  logic        opnd_a_sign = 1'b0, opnd_b_sign = 1'b0;
  logic [4:0]  rd_mode = 5'h13;
  logic [31:0] cur_psr, rd_saved;
  logic        flag_n, flag_z, flag_c, flag_v, bank_sw;
  logic [4:0]  sw_from_mode, sw_to_mode;

  always #(CLK_P/2) clk = ~clk;

  psr_unit u_psr_unit (
    .clk(clk), .rst_n(rst_n), .wr_cur_en(wr_cur_en), .wr_saved_en(wr_saved_en),
    .field_mask(field_mask), .wr_data(wr_data), .flag_kind(flag_kind),
    .opnd_a_sign(opnd_a_sign), .opnd_b_sign(opnd_b_sign), .alu_res(alu_res),
    .rd_mode(rd_mode), .cur_psr(cur_psr), .rd_saved(rd_saved),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .bank_sw(bank_sw), .sw_from_mode(sw_from_mode), .sw_to_mode(sw_to_mode)
  );

  typedef struct {
    int          due;
    logic [31:0] cur;
    logic [31:0] rd;
    logic        sw;
    logic [4:0]  from;
    logic [4:0]  to;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] m_cur = 32'h0000_00D3;
  logic [31:0] m_sav [5] = '{default: '0};

  function automatic int slot_of(input logic [4:0] m);
    case (m)
      5'h01, 5'h11: return 0;
      5'h02, 5'h12: return 1;
      5'h03, 5'h13: return 2;
      5'h17:        return 3;
      5'h1B:        return 4;
      default:      return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s): actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one operation and pushes the expected post-edge state.
  task automatic step(input logic wc, input logic ws, input logic [3:0] mk, input logic [31:0] d,
                      input logic [1:0] fk, input logic sa, input logic sb, input logic [31:0] r,
                      input logic [4:0] rm, input string tag);
    logic [31:0] nc;
    logic [3:0]  em;
    int          ci, ri;
    exp_t        e;
    @(negedge clk);
    wr_cur_en = wc; wr_saved_en = ws; field_mask = mk; wr_data = d;
    flag_kind = fk; opnd_a_sign = sa; opnd_b_sign = sb; alu_res = r; rd_mode = rm;
    nc = m_cur;
    ci = slot_of(m_cur[4:0]);
    if (wc) begin
      em = (m_cur[4:0] == 5'h00 || m_cur[4:0] == 5'h10) ? (mk & 4'b1000) : mk;
      for (int k = 0; k < 4; k++) if (em[k]) nc[k*8 +: 8] = d[k*8 +: 8];
    end else if (fk != 2'd0) begin
      nc[31] = r[31];
      nc[30] = (r == 32'd0);
      if (fk == 2'd2) begin
        nc[29] = (sa & sb) | (sa & ~r[31]) | (sb & ~r[31]);
        nc[28] = (sa == sb) && (r[31] != sa);
      end else if (fk == 2'd3) begin
        nc[29] = (sa & ~sb) | (sa & ~r[31]) | (~sb & ~r[31]);
        nc[28] = (sa != sb) && (r[31] != sa);
      end
    end
    if (ws && ci >= 0)
      for (int k = 0; k < 4; k++) if (mk[k]) m_sav[ci][k*8 +: 8] = d[k*8 +: 8];
    e.sw   = (nc[4:0] != m_cur[4:0]);
    e.from = m_cur[4:0];
    e.to   = nc[4:0];
    m_cur  = nc;
    ri     = slot_of(rm);
    e.rd   = (ri >= 0) ? m_sav[ri] : m_cur;
    e.cur  = m_cur;
    e.due  = cyc + 1;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input logic [4:0] rm, input string tag);
    step(1'b0, 1'b0, 4'h0, 32'h0, 2'd0, 1'b0, 1'b0, 32'h0, rm, tag);
  endtask

  // Monitor: pops expected items once the design has produced them.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      cyc++;
      #(CLK_P/4);
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        e = exp_q.pop_front();
        chk(e.tag, "status word", cur_psr, e.cur);
        chk(e.tag, "saved read", rd_saved, e.rd);
        chk(e.tag, "flag pins", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, e.cur[31:28]});
        chk(e.tag, "switch pulse", {31'd0, bank_sw}, {31'd0, e.sw});
        if (e.sw) chk(e.tag, "switch modes", {22'd0, sw_from_mode, sw_to_mode}, {22'd0, e.from, e.to});
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5'h13, "R1 reset state");
    step(0, 1, 4'hF, 32'h1234_5678, 0, 0, 0, 0, 5'h13, "R4 supervisor saved full");
    step(0, 1, 4'b0101, 32'hAABB_CCDD, 0, 0, 0, 0, 5'h13, "R4 supervisor saved partial");
    step(1, 0, 4'b1000, 32'h9000_0000, 0, 0, 0, 0, 5'h10, "R2 flag field, R5 user read");
    step(1, 0, 4'b0010, 32'h0000_AB00, 0, 0, 0, 0, 5'h13, "R2 extension field");
    step(1, 0, 4'b0001, 32'h0000_0012, 0, 0, 0, 0, 5'h12, "R9 switch to interrupt");
    step(0, 1, 4'hF, 32'hCAFE_0001, 0, 0, 0, 0, 5'h12, "R4 interrupt saved");
    idle(5'h13, "R4 supervisor untouched");
    step(0, 0, 0, 0, 2'd2, 0, 0, 32'h8000_0000, 5'h12, "R7 add overflow");
    step(0, 0, 0, 0, 2'd2, 1, 0, 32'h0000_0000, 5'h12, "R7 add carry to zero");
    step(0, 0, 0, 0, 2'd3, 0, 0, 32'h0000_0000, 5'h12, "R8 sub equal no borrow");
    step(0, 0, 0, 0, 2'd3, 0, 0, 32'hFFFF_FFFF, 5'h12, "R8 sub borrow");
    step(0, 0, 0, 0, 2'd3, 1, 0, 32'h7FFF_FFFF, 5'h12, "R8 sub overflow");
    step(0, 0, 0, 0, 2'd1, 1, 1, 32'h0000_0000, 5'h12, "R6 logical keeps C V");
    step(0, 0, 0, 0, 2'd1, 0, 0, 32'h4000_0000, 5'h12, "R6 positive nonzero");
    step(1, 0, 4'b1000, 32'h0000_0000, 2'd2, 0, 0, 32'h8000_0000, 5'h12, "R10 write wins");
    step(1, 0, 4'b0001, 32'h0000_0005, 0, 0, 0, 0, 5'h05, "R9 switch to bankless mode");
    step(0, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 0, 5'h05, "R4 dropped without bank");
    idle(5'h11, "R5 fast-interrupt read");
    idle(5'h01, "R5 narrow fast-interrupt read");
    idle(5'h17, "R5 abort read");
    idle(5'h1B, "R5 undefined read");
    idle(5'h1F, "R5 system read");
    idle(5'h12, "R4 interrupt unchanged");
    step(1, 0, 4'b0001, 32'h0000_0010, 0, 0, 0, 0, 5'h10, "R9 switch to user");
    step(1, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 0, 5'h10, "R3 user gate");
    step(1, 0, 4'b0111, 32'h0000_0013, 0, 0, 0, 0, 5'h10, "R3 user mode held");
    step(0, 1, 4'hF, 32'h1111_1111, 0, 0, 0, 0, 5'h12, "R4 user saved dropped");
    idle(5'h13, "R4 supervisor final");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule